// File: doc/BRIEF.md
# Asymmetric Decoder Steering Unit

This block sits between an instruction window and three decoder slots that differ in what they can do. Each cycle it looks at the three oldest pre-length-decoded instructions. Each one is tagged with the number of micro-operations it expands into. The block then decides which slots take which instructions. Slot 0 is the general slot: it takes any instruction and emits up to four micro-operations per cycle. Slots 1 and 2 are simple slots: each takes only an instruction that expands into exactly one micro-operation.

Steering follows program order. Slot `s` can only take window entry `s`, so a complex instruction that is not at the head waits one cycle until it becomes the head. An instruction that expands into more than four micro-operations is handed to a sequencer:
- In the first cycle, slot 0 emits micro-operations 0 to 3.
- In each following cycle, the sequencer emits the next four, or fewer on the last cycle.
- No other instruction is steered while the sequencer runs.

The head instruction stays in the window the whole time, because it counts as consumed only on its last chunk.

Each micro-operation appears on an output lane as a valid bit, the instruction tag and an index. The lane bundle is guarded by a single valid/ready handshake. `takeCount` tells the window how many entries to drop on a handshake cycle.

Top module: `decode_steer_unit`

## Requirements
- R1: While `rst` or `flush` is high, every output is zero. After a flush the sequencer is idle, and a long instruction still at the head restarts at micro-op index 0.
- R2: An idle unit whose head entry holds 1 to 4 micro-ops places indices 0..n-1 with the head's tag on lanes 0..n-1, and sets `slotUsed[0]`. Micro-op counts are 1..15; 0 is illegal on a valid entry.
- R3: Simple slot `s` (1 or 2) uses lane 3+s. It takes window entry `s` only if that entry holds exactly one micro-op and every older entry was taken this cycle. It emits index 0 with that entry's tag and sets `slotUsed[s]`.
- R4: The first window entry that a simple slot cannot take ends steering for the cycle. No younger entry is taken, and that entry becomes the head once the older entries are consumed.
- R5: An idle unit whose head holds more than 4 micro-ops emits indices 0..3 on lanes 0..3 and reports `takeCount` 0. After the handshake, `seqBusy` is high.
- R6: While `seqBusy` is high, lanes 0..3 carry the head's next indices, at most four per cycle, and the simple lanes stay idle. `takeCount` is 0 except on the last chunk, where it is 1, after which the unit is idle.
- R7: `outValid` is high exactly when some lane is valid. While `outReady` is low, the unit's state does not change and `takeCount` is 0.
- R8: On a handshake cycle, `takeCount` equals the number of window entries consumed: the head (if its last micro-op is emitted) plus the simple slots used.
- R9: `uopCount` equals the number of valid lanes.
- R10: With the unit idle and window entry 0 invalid, no lane is valid and `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Clears the sequencer and blanks outputs this cycle |
| instValid | input | 3 | Window entry valid bits, entry 0 oldest |
| instTag | input | 3x6 | Tag for each window entry |
| instUops | input | 3x4 | Micro-op count for each window entry |
| outReady | input | 1 | Downstream accepts the lane bundle |
| outValid | output | 1 | Lane bundle holds at least one micro-op |
| uopValid | output | 6 | Per-lane valid; lanes 0-3 general, 4-5 simple |
| uopTag | output | 6x6 | Per-lane instruction tag |
| uopIdx | output | 6x4 | Per-lane micro-op index within its instruction |
| slotUsed | output | 3 | Slot assignment mask; bit s is slot s, which takes entry s |
| uopCount | output | 3 | Number of valid lanes |
| takeCount | output | 2 | Entries to drop from the window; nonzero only on a handshake |
| seqBusy | output | 1 | Sequencer is emitting a long instruction |

## Verification
The assertions take for granted that every valid window entry has a micro-op count of at least one and that the valid bits are packed toward entry 0. They also assume that, while the sequencer runs, the head entry stays in place with a count larger than the index already reached. The bench satisfies these by acting as the window itself. It draws instructions from its own queue with counts from 1 to 15 and fills the window only from the queue's head. It removes entries only by the `takeCount` it observes. It also randomizes backpressure and occasional flushes.

// File: rtl/steer_pkg.sv
package steer_pkg;
  parameter int NUM_SLOTS = 3;
  parameter int GEN_UOPS  = 4;
  parameter int CNT_W     = 4;
  parameter int TAG_W     = 6;

  localparam int LANES     = GEN_UOPS + NUM_SLOTS - 1;
  localparam int GEN_CNT_W = $clog2(GEN_UOPS + 1);
  localparam int TAKE_W    = $clog2(NUM_SLOTS + 1);
  localparam int UCNT_W    = $clog2(LANES + 1);

  typedef struct packed {
    logic [CNT_W-1:0]     genBase;
    logic [GEN_CNT_W-1:0] genCnt;
    logic [NUM_SLOTS-1:0] slotTake;
    logic [TAKE_W-1:0]    takeCount;
  } steer_strobe_t;
endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            flush,
  input  logic                            outReady,
  input  logic [NUM_SLOTS-1:0]            instValid,
  input  logic [NUM_SLOTS-1:0][CNT_W-1:0] instUops,
  output steer_strobe_t                   strobe,
  output logic                            seqBusy
);
  localparam logic [CNT_W-1:0] GEN_LIMIT = CNT_W'(GEN_UOPS);

  logic                 busyQ;
  logic [CNT_W-1:0]     idxQ;
  logic [CNT_W-1:0]     remain;
  logic                 lastChunk, longHead, blocked, fire;
  logic [GEN_CNT_W-1:0] genCnt;
  logic [CNT_W-1:0]     genBase;
  logic [NUM_SLOTS-1:0] slotTake;
  logic [TAKE_W-1:0]    takeAll;

  assign remain    = instUops[0] - idxQ;
  assign lastChunk = remain <= GEN_LIMIT;
  assign longHead  = instValid[0] && (instUops[0] > GEN_LIMIT);
  assign blocked   = rst || flush;

  // steering decision for this cycle
  always_comb begin
    slotTake = '0;
    genCnt   = '0;
    genBase  = '0;
    takeAll  = '0;
    if (!blocked) begin
      if (busyQ) begin
        genBase = idxQ;
        genCnt  = lastChunk ? GEN_CNT_W'(remain) : GEN_CNT_W'(GEN_UOPS);
        takeAll = lastChunk ? TAKE_W'(1) : '0;
      end else if (longHead) begin
        genCnt = GEN_CNT_W'(GEN_UOPS);
      end else if (instValid[0]) begin
        genCnt      = GEN_CNT_W'(instUops[0]);
        slotTake[0] = 1'b1;
        for (int s = 1; s < NUM_SLOTS; s++) begin
          slotTake[s] = slotTake[s-1] && instValid[s] && (instUops[s] == CNT_W'(1));
        end
        takeAll = TAKE_W'($countones(slotTake));
      end
    end
  end

  assign fire = (genCnt != '0) && outReady;

  always_comb begin
    strobe.genBase   = genBase;
    strobe.genCnt    = genCnt;
    strobe.slotTake  = slotTake;
    strobe.takeCount = fire ? takeAll : '0;
  end

  assign seqBusy = busyQ && !blocked;

  always_ff @(posedge clk) begin
    if (blocked) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (fire) begin
      if (busyQ) begin
        if (lastChunk) begin
          busyQ <= 1'b0;
          idxQ  <= '0;
        end else begin
          idxQ <= idxQ + GEN_LIMIT;
        end
      end else if (longHead) begin
        busyQ <= 1'b1;
        idxQ  <= GEN_LIMIT;
      end
    end
  end

  assert_flush_clears_R1: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!busyQ && idxQ == '0));

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (genCnt != '0 && !outReady && !flush) |=> ($stable(busyQ) && $stable(idxQ)));

  assert_long_start_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && !busyQ && longHead) |=> (busyQ && idxQ == GEN_LIMIT));

  // input assumption: head held in place while the sequencer runs
  assert_seq_source_R6: assert property (@(posedge clk) disable iff (rst)
    (busyQ && !flush) |-> (instValid[0] && instUops[0] > idxQ));
endmodule

// File: rtl/steer_datapath.sv
module steer_datapath
  import steer_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  steer_strobe_t                   strobe,
  input  logic [NUM_SLOTS-1:0]            instValid,
  input  logic [NUM_SLOTS-1:0][TAG_W-1:0] instTag,
  input  logic [NUM_SLOTS-1:0][CNT_W-1:0] instUops,
  output logic                            outValid,
  output logic [LANES-1:0]                uopValid,
  output logic [LANES-1:0][TAG_W-1:0]     uopTag,
  output logic [LANES-1:0][CNT_W-1:0]     uopIdx,
  output logic [NUM_SLOTS-1:0]            slotUsed,
  output logic [UCNT_W-1:0]               uopCount,
  output logic [TAKE_W-1:0]               takeCount
);
  // general slot lanes
  for (genvar g = 0; g < GEN_UOPS; g++) begin : genLane
    assign uopValid[g] = GEN_CNT_W'(g) < strobe.genCnt;
    assign uopTag[g]   = uopValid[g] ? instTag[0] : '0;
    assign uopIdx[g]   = uopValid[g] ? (strobe.genBase + CNT_W'(g)) : '0;
    if (g > 0) begin : packedChk
      assert_lanes_packed_R2: assert property (@(posedge clk) disable iff (rst)
        uopValid[g] |-> uopValid[g-1]);
    end
  end

  // simple slot lanes
  for (genvar s = 1; s < NUM_SLOTS; s++) begin : simpleLane
    localparam int L = GEN_UOPS + s - 1;
    assign uopValid[L] = strobe.slotTake[s];
    assign uopTag[L]   = strobe.slotTake[s] ? instTag[s] : '0;
    assign uopIdx[L]   = '0;
    assign slotUsed[s] = strobe.slotTake[s];
    assert_simple_single_R3: assert property (@(posedge clk) disable iff (rst)
      uopValid[L] |-> (instValid[s] && instUops[s] == CNT_W'(1) && uopValid[0]));
  end

  assign slotUsed[0] = strobe.genCnt != '0;

  always_comb begin
    uopCount = '0;
    for (int l = 0; l < LANES; l++) begin
      uopCount = uopCount + UCNT_W'(uopValid[l]);
    end
  end

  assign outValid  = |uopValid;
  assign takeCount = strobe.takeCount;

  assert_lane_count_R9: assert property (@(posedge clk) disable iff (rst)
    uopCount == UCNT_W'($countones(uopValid)));

  assert_take_needs_output_R8: assert property (@(posedge clk) disable iff (rst)
    (takeCount != '0) |-> outValid);

  // input assumption: valid entries carry a nonzero count
  for (genvar e = 0; e < NUM_SLOTS; e++) begin : cntChk
    assert_count_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
      instValid[e] |-> (instUops[e] != '0));
  end
endmodule

// File: rtl/decode_steer_unit.sv
module decode_steer_unit
  import steer_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            flush,
  input  logic [NUM_SLOTS-1:0]            instValid,
  input  logic [NUM_SLOTS-1:0][TAG_W-1:0] instTag,
  input  logic [NUM_SLOTS-1:0][CNT_W-1:0] instUops,
  input  logic                            outReady,
  output logic                            outValid,
  output logic [LANES-1:0]                uopValid,
  output logic [LANES-1:0][TAG_W-1:0]     uopTag,
  output logic [LANES-1:0][CNT_W-1:0]     uopIdx,
  output logic [NUM_SLOTS-1:0]            slotUsed,
  output logic [UCNT_W-1:0]               uopCount,
  output logic [TAKE_W-1:0]               takeCount,
  output logic                            seqBusy
);
  steer_strobe_t strobe;

  steer_ctrl ctrl (
    .clk(clk), .rst(rst), .flush(flush), .outReady(outReady),
    .instValid(instValid), .instUops(instUops),
    .strobe(strobe), .seqBusy(seqBusy)
  );

  steer_datapath dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .instValid(instValid), .instTag(instTag), .instUops(instUops),
    .outValid(outValid), .uopValid(uopValid), .uopTag(uopTag), .uopIdx(uopIdx),
    .slotUsed(slotUsed), .uopCount(uopCount), .takeCount(takeCount)
  );
endmodule

// File: tb/decode_steer_unit_test.sv
module decode_steer_unit_test;
  import steer_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                            rst, flush, outReady;
  logic [NUM_SLOTS-1:0]            instValid;
  logic [NUM_SLOTS-1:0][TAG_W-1:0] instTag;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] instUops;
  logic                            outValid, seqBusy;
  logic [LANES-1:0]                uopValid;
  logic [LANES-1:0][TAG_W-1:0]     uopTag;
  logic [LANES-1:0][CNT_W-1:0]     uopIdx;
  logic [NUM_SLOTS-1:0]            slotUsed;
  logic [UCNT_W-1:0]               uopCount;
  logic [TAKE_W-1:0]               takeCount;

  decode_steer_unit uut (
    .clk(clk), .rst(rst), .flush(flush), .instValid(instValid), .instTag(instTag),
    .instUops(instUops), .outReady(outReady), .outValid(outValid), .uopValid(uopValid),
    .uopTag(uopTag), .uopIdx(uopIdx), .slotUsed(slotUsed), .uopCount(uopCount),
    .takeCount(takeCount), .seqBusy(seqBusy)
  );

  int nChecks = 0;
  int nFails  = 0;
  int qTag[0:2047];
  int qUops[0:2047];
  int head = 0;
  int tail = 0;
  bit mBusy = 0;
  int mIdx = 0;

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(int u);
    qUops[tail] = u;
    qTag[tail]  = tail % 64;
    tail++;
  endtask

  // one cycle: drive window, check outputs against model, advance model
  task automatic step(bit ready, bit fl);
    int v[NUM_SLOTS];
    int u[NUM_SLOTS];
    int t[NUM_SLOTS];
    int cnt, base, take, rem, nSimple, mask, expTake;
    bit sEn[NUM_SLOTS];
    bit fire;
    string req;
    @(negedge clk);
    for (int k = 0; k < NUM_SLOTS; k++) begin
      v[k] = (head + k < tail) ? 1 : 0;
      u[k] = v[k] ? qUops[head + k] : 0;
      t[k] = v[k] ? qTag[head + k] : 0;
      instValid[k] = v[k][0];
      instUops[k]  = CNT_W'(u[k]);
      instTag[k]   = TAG_W'(t[k]);
      sEn[k] = 0;
    end
    outReady = ready;
    flush = fl;
    #1;
    cnt = 0; base = 0; take = 0; rem = 0;
    if (!fl) begin
      if (mBusy) begin
        rem = u[0] - mIdx;
        base = mIdx;
        cnt = (rem > GEN_UOPS) ? GEN_UOPS : rem;
        take = (rem <= GEN_UOPS) ? 1 : 0;
      end else if (v[0] == 1 && u[0] > GEN_UOPS) begin
        cnt = GEN_UOPS;
      end else if (v[0] == 1) begin
        cnt = u[0];
        take = 1;
        sEn[0] = 1;
        for (int s = 1; s < NUM_SLOTS; s++) begin
          sEn[s] = sEn[s-1] && v[s] == 1 && u[s] == 1;
          if (sEn[s]) take++;
        end
      end
    end
    nSimple = 0;
    for (int s = 1; s < NUM_SLOTS; s++) if (sEn[s]) nSimple++;
    fire = (cnt > 0) && ready;
    expTake = fire ? take : 0;
    if (fl) req = "R1";
    else if (mBusy) req = "R6";
    else if (v[0] == 0) req = "R10";
    else if (u[0] > GEN_UOPS) req = "R5";
    else req = "R2";
    for (int j = 0; j < GEN_UOPS; j++) begin
      chk({req, " lane valid"}, int'(uopValid[j]), (j < cnt) ? 1 : 0);
      if (j < cnt) begin
        chk({req, " lane tag"}, int'(uopTag[j]), t[0]);
        chk({req, " lane idx"}, int'(uopIdx[j]), base + j);
      end
    end
    for (int s = 1; s < NUM_SLOTS; s++) begin
      string sr;
      sr = (!sEn[s] && v[s] == 1 && u[s] == 1 && !fl && !mBusy) ? "R4" : (mBusy ? "R6" : "R3");
      chk({sr, " simple valid"}, int'(uopValid[GEN_UOPS+s-1]), int'(sEn[s]));
      if (sEn[s]) begin
        chk("R3 simple tag", int'(uopTag[GEN_UOPS+s-1]), t[s]);
        chk("R3 simple idx", int'(uopIdx[GEN_UOPS+s-1]), 0);
      end
    end
    mask = (cnt > 0) ? 1 : 0;
    for (int s = 1; s < NUM_SLOTS; s++) if (sEn[s]) mask |= (1 << s);
    chk("R3 slotUsed", int'(slotUsed), mask);
    chk(fl ? "R1 takeCount" : (ready ? "R8 takeCount" : "R7 takeCount"), int'(takeCount), expTake);
    chk("R9 uopCount", int'(uopCount), cnt + nSimple);
    chk(fl ? "R1 outValid" : "R7 outValid", int'(outValid), (cnt > 0) ? 1 : 0);
    chk(fl ? "R1 seqBusy" : "R6 seqBusy", int'(seqBusy), fl ? 0 : int'(mBusy));
    if (fl) begin
      mBusy = 0;
      mIdx = 0;
    end else if (fire) begin
      if (mBusy) begin
        if (rem <= GEN_UOPS) begin mBusy = 0; mIdx = 0; end
        else mIdx += GEN_UOPS;
      end else if (v[0] == 1 && u[0] > GEN_UOPS) begin
        mBusy = 1;
        mIdx = GEN_UOPS;
      end
      head += expTake;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && (head < tail || mBusy); i++) step(1, 0);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1; flush = 0; outReady = 1;
    instValid = '1; instTag = '0;
    for (int k = 0; k < NUM_SLOTS; k++) instUops[k] = CNT_W'(1);
    repeat (3) begin
      @(negedge clk);
      #1;
      chk("R1 reset outValid", int'(outValid), 0);
      chk("R1 reset uopCount", int'(uopCount), 0);
      chk("R1 reset takeCount", int'(takeCount), 0);
      chk("R1 reset slotUsed", int'(slotUsed), 0);
    end
    @(negedge clk);
    rst = 0;

    // R10: empty window
    step(1, 0);
    // R2/R3/R4 directed orderings
    push(1); push(1); push(1);
    push(2); push(1); push(1);
    push(1); push(3); push(1);
    push(1); push(1); push(4);
    push(4); push(2); push(1);
    drain();
    // R5/R6: long instructions of several lengths
    push(5); push(1); push(8); push(9); push(15); push(1); push(1);
    drain();
    // R7: stall in the middle of a sequence
    push(11); push(1);
    step(1, 0); step(0, 0); step(0, 0); step(0, 0); step(1, 0);
    drain();
    // R1: flush in the middle of a sequence, restart from index 0
    push(9); push(1);
    step(1, 0); step(1, 1);
    drain();

    // constrained random
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 900; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 6) push(1);
      else if (r < 8) push(2 + ($urandom % 3));
      else push(5 + ($urandom % 11));
    end
    for (int c = 0; c < 20000 && (head < tail || mBusy); c++) begin
      step(($urandom % 4) != 0, ($urandom % 97) == 0);
    end
    drain();
    step(1, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule